// File: doc/BRIEF.md
# Out-of-Order Reservation Station

This block is the waiting area between instruction issue and the ALU in a dynamically scheduled core. Issue hands it one instruction per cycle; the block parks it in the lowest free slot and gathers both source operands. One cycle after a slot is taken, the block receives the register-file answer for each source (a clean value, or the producer's reorder-buffer tag) together with a reorder-buffer value lookup. A source still missing after that is tracked by tag and filled in when a result with the same tag appears on either of two completion buses, one from the ALU and one from memory.

Every cycle the lowest-numbered slot whose sources are all present is sent to the ALU with its identifier, operands, immediate, shift amount, program counter and reorder-buffer tag, and the slot is released. A free-slot count tells issue how much room is left. A flush input empties the buffer in one cycle, with the same effect as reset.

Top module: `rsv_station`

## Requirements
- R1: The buffer holds ENTRIES (default 32) slots, each free, awaiting lookup, or waiting; after ENTRIES issues with unresolved sources the free-slot count reads 0.
- R2: An issue strobe with issue kind 0 takes the lowest-numbered free slot; with issue kind 1 the strobe is ignored and the free-slot count and dispatch output are unchanged.
- R3: In the cycle after a slot is taken, each present source takes the register-file value when the register file reports it clean, otherwise the reorder-buffer value when the reorder buffer reports a hit.
- R4: A present source resolved by neither lookup compares the register-file tag with both completion buses in that same lookup cycle and takes the value on a match (ALU bus preferred); without a match it records the tag and waits.
- R5: A waiting slot captures a completion value only when the bus status equals 2'b10 and the bus tag equals the recorded tag; the ALU bus wins when both buses match.
- R6: A source whose present flag is 0 never blocks dispatch and is delivered as value 0.
- R7: Each cycle the lowest-numbered waiting slot whose present sources are all resolved is dispatched and freed; when none is ready the dispatch identifier output is 0 and the other dispatch outputs hold.
- R8: A slot taken at clock edge N cannot be dispatched before edge N+2, so its dispatch outputs are first visible after edge N+2.
- R9: The free-slot count equals the number of free slots at all times, falling by one on an accepted issue and rising by one on a dispatch in the same cycle.
- R10: Reset and flush both free every slot, set the count to ENTRIES, set the dispatch identifier to 0 and cancel a pending lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous clear of all slots |
| iss_valid_i | input | 1 | Issue strobe |
| iss_kind_i | input | 1 | Issue kind, 0 = for this buffer |
| iss_rob_i | input | 5 | Reorder-buffer tag of the issued instruction |
| iss_id_i | input | 11 | Instruction identifier (nonzero) |
| iss_pc_i | input | 32 | Program counter |
| iss_imm_i | input | 32 | Immediate |
| iss_shamt_i | input | 6 | Shift amount |
| iss_src1_en_i | input | 1 | Source 1 present |
| iss_src2_en_i | input | 1 | Source 2 present |
| rf1_clean_i | input | 1 | Source 1 has no pending producer |
| rf1_tag_i | input | 5 | Source 1 producer tag |
| rf1_val_i | input | 32 | Source 1 register value |
| rob1_hit_i | input | 1 | Source 1 value present in reorder buffer |
| rob1_val_i | input | 32 | Source 1 reorder-buffer value |
| rf2_clean_i | input | 1 | Source 2 has no pending producer |
| rf2_tag_i | input | 5 | Source 2 producer tag |
| rf2_val_i | input | 32 | Source 2 register value |
| rob2_hit_i | input | 1 | Source 2 value present in reorder buffer |
| rob2_val_i | input | 32 | Source 2 reorder-buffer value |
| alu_stat_i | input | 2 | ALU completion status, 2'b10 = valid |
| alu_tag_i | input | 5 | ALU completion tag |
| alu_val_i | input | 32 | ALU completion value |
| mem_stat_i | input | 2 | Memory completion status, 2'b10 = valid |
| mem_tag_i | input | 5 | Memory completion tag |
| mem_val_i | input | 32 | Memory completion value |
| dsp_id_o | output | 11 | Dispatched identifier, 0 = none |
| dsp_op1_o | output | 32 | Dispatched source 1 value |
| dsp_op2_o | output | 32 | Dispatched source 2 value |
| dsp_imm_o | output | 32 | Dispatched immediate |
| dsp_shamt_o | output | 6 | Dispatched shift amount |
| dsp_pc_o | output | 32 | Dispatched program counter |
| dsp_rob_o | output | 5 | Dispatched reorder-buffer tag |
| free_cnt_o | output | 6 | Free-slot count |

## Verification
Directed sequences drive each source-resolution path separately: clean register value, reorder-buffer hit, a bypass caught on each bus inside the lookup cycle, and a late capture after an invalid-status broadcast with the right tag; mixing them up would show as a wrong operand value. A back-to-back fill of every slot followed by one broadcast releasing them all separates lowest-index dispatch order from any other order, and an issue of kind 1 and absent sources show whether the ignore and no-wait rules hold. A long random phase with a narrow tag range then makes both buses hit often and at once, with flushes in between, so same-cycle capture, allocation and dispatch interact with the count.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int RSV_XLEN  = 32;
  localparam int RSV_TAG_W = 5;
  localparam int RSV_ID_W  = 11;
  localparam int RSV_SH_W  = 6;

  localparam logic [1:0] BUS_DONE = 2'b10;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2
  } slot_st_e;

  typedef struct packed {
    logic [RSV_ID_W-1:0]  id;
    logic [RSV_XLEN-1:0]  pc;
    logic [RSV_XLEN-1:0]  imm;
    logic [RSV_SH_W-1:0]  shamt;
    logic [RSV_TAG_W-1:0] rob;
  } payload_t;

  typedef struct packed {
    logic                 res;
    logic [RSV_TAG_W-1:0] tag;
    logic [RSV_XLEN-1:0]  val;
  } opnd_t;

  typedef struct packed {
    logic [1:0]           stat;
    logic [RSV_TAG_W-1:0] tag;
    logic [RSV_XLEN-1:0]  val;
  } bus_t;

  function automatic logic bus_hit(bus_t b, logic [RSV_TAG_W-1:0] t);
    return (b.stat == BUS_DONE) && (b.tag == t);
  endfunction
endpackage

// File: rtl/rsv_pick.sv
module rsv_pick #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/rsv_resolve.sv
module rsv_resolve import rsv_pkg::*; (
  input  logic                 rf_clean_i,
  input  logic [RSV_TAG_W-1:0] rf_tag_i,
  input  logic [RSV_XLEN-1:0]  rf_val_i,
  input  logic                 rob_hit_i,
  input  logic [RSV_XLEN-1:0]  rob_val_i,
  input  bus_t                 alu_i,
  input  bus_t                 mem_i,
  output opnd_t                opnd_o
);
  always_comb begin
    opnd_o.res = 1'b1;
    opnd_o.tag = rf_tag_i;
    if (rf_clean_i)                   opnd_o.val = rf_val_i;
    else if (rob_hit_i)               opnd_o.val = rob_val_i;
    else if (bus_hit(alu_i, rf_tag_i)) opnd_o.val = alu_i.val;
    else if (bus_hit(mem_i, rf_tag_i)) opnd_o.val = mem_i.val;
    else begin
      opnd_o.val = '0;
      opnd_o.res = 1'b0;
    end
  end
endmodule

// File: rtl/rsv_slot.sv
module rsv_slot import rsv_pkg::*; (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       alloc_i,
  input  payload_t                   alloc_pay_i,
  input  logic [1:0]                 alloc_en_i,
  input  logic                       lookup_i,
  input  opnd_t [1:0]                lk_opnd_i,
  input  logic                       grant_i,
  input  bus_t                       alu_i,
  input  bus_t                       mem_i,
  output slot_st_e                   st_o,
  output logic                       rdy_o,
  output payload_t                   pay_o,
  output logic [1:0][RSV_XLEN-1:0]   val_o
);
  slot_st_e    st_q, st_d;
  payload_t    pay_q;
  logic [1:0]  en_q, en_d;
  opnd_t [1:0] op_q, op_d;
  logic        pay_we, op_we;

  assign pay_we = alloc_i & ~clr_i;
  assign op_we  = ~clr_i & (alloc_i | lookup_i | (st_q == ST_WAIT));

  always_comb begin
    st_d = st_q;
    en_d = en_q;
    op_d = op_q;
    if (clr_i) begin
      st_d = ST_FREE;
    end else if (alloc_i) begin
      st_d = ST_LOOK;
      en_d = alloc_en_i;
      for (int k = 0; k < 2; k++) op_d[k] = '{res: 1'b1, tag: '0, val: '0};
    end else if (lookup_i) begin
      st_d = ST_WAIT;
      for (int k = 0; k < 2; k++) begin
        if (en_q[k]) op_d[k] = lk_opnd_i[k];
      end
    end else if (st_q == ST_WAIT) begin
      if (grant_i) begin
        st_d = ST_FREE;
      end else begin
        for (int k = 0; k < 2; k++) begin
          if (en_q[k] && !op_q[k].res) begin
            if (bus_hit(alu_i, op_q[k].tag)) begin
              op_d[k].val = alu_i.val;
              op_d[k].res = 1'b1;
            end else if (bus_hit(mem_i, op_q[k].tag)) begin
              op_d[k].val = mem_i.val;
              op_d[k].res = 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FREE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (pay_we) pay_q <= alloc_pay_i;
  end

  always_ff @(posedge clk) begin
    if (op_we) begin
      en_q <= en_d;
      op_q <= op_d;
    end
  end

  assign st_o  = st_q;
  assign rdy_o = (st_q == ST_WAIT) && (!en_q[0] || op_q[0].res) && (!en_q[1] || op_q[1].res);
  assign pay_o = pay_q;
  assign val_o = {op_q[1].val, op_q[0].val};

  // R7: a slot is only granted when its own view says it is ready
  a_r7_grant_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> rdy_o);

  // R3: the lookup strobe only reaches a slot that is awaiting lookup
  a_r3_lookup_on_look: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_i |-> (st_q == ST_LOOK));
endmodule

// File: rtl/rsv_station.sv
module rsv_station import rsv_pkg::*; #(
  parameter int ENTRIES = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush_i,
  input  logic                          iss_valid_i,
  input  logic                          iss_kind_i,
  input  logic [RSV_TAG_W-1:0]          iss_rob_i,
  input  logic [RSV_ID_W-1:0]           iss_id_i,
  input  logic [RSV_XLEN-1:0]           iss_pc_i,
  input  logic [RSV_XLEN-1:0]           iss_imm_i,
  input  logic [RSV_SH_W-1:0]           iss_shamt_i,
  input  logic                          iss_src1_en_i,
  input  logic                          iss_src2_en_i,
  input  logic                          rf1_clean_i,
  input  logic [RSV_TAG_W-1:0]          rf1_tag_i,
  input  logic [RSV_XLEN-1:0]           rf1_val_i,
  input  logic                          rob1_hit_i,
  input  logic [RSV_XLEN-1:0]           rob1_val_i,
  input  logic                          rf2_clean_i,
  input  logic [RSV_TAG_W-1:0]          rf2_tag_i,
  input  logic [RSV_XLEN-1:0]           rf2_val_i,
  input  logic                          rob2_hit_i,
  input  logic [RSV_XLEN-1:0]           rob2_val_i,
  input  logic [1:0]                    alu_stat_i,
  input  logic [RSV_TAG_W-1:0]          alu_tag_i,
  input  logic [RSV_XLEN-1:0]           alu_val_i,
  input  logic [1:0]                    mem_stat_i,
  input  logic [RSV_TAG_W-1:0]          mem_tag_i,
  input  logic [RSV_XLEN-1:0]           mem_val_i,
  output logic [RSV_ID_W-1:0]           dsp_id_o,
  output logic [RSV_XLEN-1:0]           dsp_op1_o,
  output logic [RSV_XLEN-1:0]           dsp_op2_o,
  output logic [RSV_XLEN-1:0]           dsp_imm_o,
  output logic [RSV_SH_W-1:0]           dsp_shamt_o,
  output logic [RSV_XLEN-1:0]           dsp_pc_o,
  output logic [RSV_TAG_W-1:0]          dsp_rob_o,
  output logic [$clog2(ENTRIES+1)-1:0]  free_cnt_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(ENTRIES + 1);
  localparam logic ISS_KIND_LOCAL = 1'b0;

  slot_st_e                  slot_st [ENTRIES];
  payload_t                  pay_v   [ENTRIES];
  logic [1:0][RSV_XLEN-1:0]  val_v   [ENTRIES];
  logic [ENTRIES-1:0]        free_vec, rdy_vec, alloc_vec, lk_vec, gnt_vec;

  logic              alloc_found, gnt_found, accept, gnt_eff;
  logic [IDX_W-1:0]  alloc_idx, gnt_idx;

  logic              lk_pend_q, lk_pend_d;
  logic [IDX_W-1:0]  lk_idx_q, lk_idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic [RSV_ID_W-1:0] id_q, id_d;
  payload_t            dsp_pay_q;
  logic [1:0][RSV_XLEN-1:0] dsp_val_q;

  bus_t        alu_bus, mem_bus;
  payload_t    iss_pay;
  opnd_t [1:0] lk_opnd;

  logic [1:0]                rf_clean, rob_hit;
  logic [1:0][RSV_TAG_W-1:0] rf_tag;
  logic [1:0][RSV_XLEN-1:0]  rf_val, rob_val;

  assign alu_bus = '{stat: alu_stat_i, tag: alu_tag_i, val: alu_val_i};
  assign mem_bus = '{stat: mem_stat_i, tag: mem_tag_i, val: mem_val_i};
  assign iss_pay = '{id: iss_id_i, pc: iss_pc_i, imm: iss_imm_i,
                     shamt: iss_shamt_i, rob: iss_rob_i};

  assign rf_clean = {rf2_clean_i, rf1_clean_i};
  assign rf_tag   = {rf2_tag_i, rf1_tag_i};
  assign rf_val   = {rf2_val_i, rf1_val_i};
  assign rob_hit  = {rob2_hit_i, rob1_hit_i};
  assign rob_val  = {rob2_val_i, rob1_val_i};

  // one lookup resolver per source operand
  for (genvar k = 0; k < 2; k++) begin : g_res
    rsv_resolve u_res (
      .rf_clean_i (rf_clean[k]),
      .rf_tag_i   (rf_tag[k]),
      .rf_val_i   (rf_val[k]),
      .rob_hit_i  (rob_hit[k]),
      .rob_val_i  (rob_val[k]),
      .alu_i      (alu_bus),
      .mem_i      (mem_bus),
      .opnd_o     (lk_opnd[k])
    );
  end

  rsv_pick #(.N(ENTRIES), .IW(IDX_W)) u_alloc_pick (
    .req_i (free_vec), .found_o (alloc_found), .idx_o (alloc_idx));

  rsv_pick #(.N(ENTRIES), .IW(IDX_W)) u_gnt_pick (
    .req_i (rdy_vec), .found_o (gnt_found), .idx_o (gnt_idx));

  assign accept  = iss_valid_i && (iss_kind_i == ISS_KIND_LOCAL) && alloc_found && !flush_i;
  assign gnt_eff = gnt_found && !flush_i;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign alloc_vec[i] = accept    && (alloc_idx == IDX_W'(i));
    assign lk_vec[i]    = lk_pend_q && (lk_idx_q  == IDX_W'(i));
    assign gnt_vec[i]   = gnt_eff   && (gnt_idx   == IDX_W'(i));
    assign free_vec[i]  = (slot_st[i] == ST_FREE);

    rsv_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (flush_i),
      .alloc_i     (alloc_vec[i]),
      .alloc_pay_i (iss_pay),
      .alloc_en_i  ({iss_src2_en_i, iss_src1_en_i}),
      .lookup_i    (lk_vec[i]),
      .lk_opnd_i   (lk_opnd),
      .grant_i     (gnt_vec[i]),
      .alu_i       (alu_bus),
      .mem_i       (mem_bus),
      .st_o        (slot_st[i]),
      .rdy_o       (rdy_vec[i]),
      .pay_o       (pay_v[i]),
      .val_o       (val_v[i])
    );
  end

  always_comb begin
    lk_pend_d = accept;
    lk_idx_d  = accept ? alloc_idx : lk_idx_q;
    id_d      = gnt_eff ? pay_v[gnt_idx].id : '0;
    if (flush_i) cnt_d = CNT_W'(ENTRIES);
    else         cnt_d = cnt_q - CNT_W'(accept) + CNT_W'(gnt_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_pend_q <= 1'b0;
      lk_idx_q  <= '0;
      cnt_q     <= CNT_W'(ENTRIES);
      id_q      <= '0;
    end else begin
      lk_pend_q <= lk_pend_d;
      lk_idx_q  <= lk_idx_d;
      cnt_q     <= cnt_d;
      id_q      <= id_d;
    end
  end

  always_ff @(posedge clk) begin
    if (gnt_eff) begin
      dsp_pay_q <= pay_v[gnt_idx];
      dsp_val_q <= val_v[gnt_idx];
    end
  end

  assign dsp_id_o    = id_q;
  assign dsp_op1_o   = dsp_val_q[0];
  assign dsp_op2_o   = dsp_val_q[1];
  assign dsp_imm_o   = dsp_pay_q.imm;
  assign dsp_shamt_o = dsp_pay_q.shamt;
  assign dsp_pc_o    = dsp_pay_q.pc;
  assign dsp_rob_o   = dsp_pay_q.rob;
  assign free_cnt_o  = cnt_q;

  // R9: the counter agrees with the slots' own states
  a_r9_count_matches_slots: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(free_vec) == int'(cnt_q));

  // R2: issue for this buffer never arrives while it is full
  a_r2_no_issue_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid_i && iss_kind_i == ISS_KIND_LOCAL) |-> (cnt_q != '0));

  // R8: the slot under lookup is waiting one edge later
  a_r8_lookup_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_pend_q && !flush_i) |=> (slot_st[$past(lk_idx_q)] == ST_WAIT));

  // R10: flush empties the buffer and silences dispatch
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (free_cnt_o == CNT_W'(ENTRIES) && dsp_id_o == '0 && !lk_pend_q));
endmodule

// File: tb/rsv_station_tb_top.sv
`timescale 1ns/1ps
module rsv_station_tb_top;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        flush, iss_v, iss_k, e1, e2;
  logic [4:0]  iss_rob, rf1_tag, rf2_tag, alu_tag, mem_tag;
  logic [10:0] iss_id;
  logic [31:0] iss_pc, iss_imm, rf1_val, rf2_val, rob1_val, rob2_val, alu_val, mem_val;
  logic [5:0]  iss_sh;
  logic        rf1_clean, rf2_clean, rob1_hit, rob2_hit;
  logic [1:0]  alu_stat, mem_stat;

  logic [10:0] dsp_id;
  logic [31:0] dsp_op1, dsp_op2, dsp_imm, dsp_pc;
  logic [5:0]  dsp_sh, free_cnt;
  logic [4:0]  dsp_rob;

  rsv_station dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .iss_valid_i(iss_v), .iss_kind_i(iss_k), .iss_rob_i(iss_rob), .iss_id_i(iss_id),
    .iss_pc_i(iss_pc), .iss_imm_i(iss_imm), .iss_shamt_i(iss_sh),
    .iss_src1_en_i(e1), .iss_src2_en_i(e2),
    .rf1_clean_i(rf1_clean), .rf1_tag_i(rf1_tag), .rf1_val_i(rf1_val),
    .rob1_hit_i(rob1_hit), .rob1_val_i(rob1_val),
    .rf2_clean_i(rf2_clean), .rf2_tag_i(rf2_tag), .rf2_val_i(rf2_val),
    .rob2_hit_i(rob2_hit), .rob2_val_i(rob2_val),
    .alu_stat_i(alu_stat), .alu_tag_i(alu_tag), .alu_val_i(alu_val),
    .mem_stat_i(mem_stat), .mem_tag_i(mem_tag), .mem_val_i(mem_val),
    .dsp_id_o(dsp_id), .dsp_op1_o(dsp_op1), .dsp_op2_o(dsp_op2), .dsp_imm_o(dsp_imm),
    .dsp_shamt_o(dsp_sh), .dsp_pc_o(dsp_pc), .dsp_rob_o(dsp_rob), .free_cnt_o(free_cnt)
  );

  // behavioural reference model
  int          m_st [N];
  logic [10:0] m_id [N];
  logic [31:0] m_pc [N], m_imm [N];
  logic [5:0]  m_sh [N];
  logic [4:0]  m_rob [N];
  bit          m_e [N][2], m_r [N][2];
  logic [4:0]  m_q [N][2];
  logic [31:0] m_v [N][2];
  int          m_cnt, m_lki;
  bit          m_lkp;
  logic [10:0] x_id;
  logic [31:0] x_op1, x_op2, x_imm, x_pc;
  logic [5:0]  x_sh;
  logic [4:0]  x_rob;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic bit hit(logic [1:0] s, logic [4:0] bt, logic [4:0] t);
    return (s == 2'b10) && (bt == t);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_st[i] = 0;
    m_cnt = N; m_lkp = 0; m_lki = 0; x_id = '0;
  endtask

  task automatic model_step();
    int g;
    bit clean [2], rh [2];
    logic [4:0] rt [2];
    logic [31:0] rv [2], ov [2];
    if (flush) begin model_reset(); return; end
    clean = '{rf1_clean, rf2_clean}; rh = '{rob1_hit, rob2_hit};
    rt = '{rf1_tag, rf2_tag}; rv = '{rf1_val, rf2_val}; ov = '{rob1_val, rob2_val};
    g = -1;
    for (int i = 0; i < N; i++)
      if (g < 0 && m_st[i] == 2 && (!m_e[i][0] || m_r[i][0]) && (!m_e[i][1] || m_r[i][1])) g = i;
    for (int i = 0; i < N; i++) begin
      if (i != g && m_st[i] == 2) begin
        for (int k = 0; k < 2; k++) begin
          if (m_e[i][k] && !m_r[i][k]) begin
            if (hit(alu_stat, alu_tag, m_q[i][k]))      begin m_v[i][k] = alu_val; m_r[i][k] = 1; end
            else if (hit(mem_stat, mem_tag, m_q[i][k])) begin m_v[i][k] = mem_val; m_r[i][k] = 1; end
          end
        end
      end
    end
    if (m_lkp) begin
      for (int k = 0; k < 2; k++) begin
        if (m_e[m_lki][k]) begin
          m_r[m_lki][k] = 1;
          if (clean[k])                          m_v[m_lki][k] = rv[k];
          else if (rh[k])                        m_v[m_lki][k] = ov[k];
          else if (hit(alu_stat, alu_tag, rt[k])) m_v[m_lki][k] = alu_val;
          else if (hit(mem_stat, mem_tag, rt[k])) m_v[m_lki][k] = mem_val;
          else begin m_r[m_lki][k] = 0; m_q[m_lki][k] = rt[k]; end
        end
      end
      m_st[m_lki] = 2;
    end
    m_lkp = 0;
    if (iss_v && !iss_k) begin
      int a = -1;
      for (int i = 0; i < N; i++) if (a < 0 && m_st[i] == 0) a = i;
      if (a >= 0) begin
        m_st[a] = 1; m_id[a] = iss_id; m_pc[a] = iss_pc; m_imm[a] = iss_imm;
        m_sh[a] = iss_sh; m_rob[a] = iss_rob;
        m_e[a][0] = e1; m_e[a][1] = e2; m_r[a][0] = 1; m_r[a][1] = 1;
        m_v[a][0] = '0; m_v[a][1] = '0;
        m_lkp = 1; m_lki = a; m_cnt--;
      end
    end
    if (g >= 0) begin
      x_id = m_id[g]; x_op1 = m_v[g][0]; x_op2 = m_v[g][1]; x_imm = m_imm[g];
      x_pc = m_pc[g]; x_sh = m_sh[g]; x_rob = m_rob[g];
      m_st[g] = 0; m_cnt++;
    end else begin
      x_id = '0;
    end
  endtask

  task automatic check_eq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check_eq("R9", "free count", free_cnt, m_cnt);
    check_eq("R7", "dispatch id", dsp_id, x_id);
    if (x_id != '0) begin
      check_eq("R3 R4 R5 R6", "operand 1", dsp_op1, x_op1);
      check_eq("R3 R4 R5 R6", "operand 2", dsp_op2, x_op2);
      check_eq("R7", "immediate", dsp_imm, x_imm);
      check_eq("R7", "pc", dsp_pc, x_pc);
      check_eq("R7", "shamt", dsp_sh, x_sh);
      check_eq("R7", "rob tag", dsp_rob, x_rob);
    end
  endtask

  task automatic idle();
    flush = 0; iss_v = 0; iss_k = 0; e1 = 0; e2 = 0;
    iss_rob = '0; iss_id = '0; iss_pc = '0; iss_imm = '0; iss_sh = '0;
    rf1_clean = 1; rf2_clean = 1; rf1_tag = '0; rf2_tag = '0; rf1_val = '0; rf2_val = '0;
    rob1_hit = 0; rob2_hit = 0; rob1_val = '0; rob2_val = '0;
    alu_stat = 2'b00; mem_stat = 2'b00; alu_tag = '0; mem_tag = '0; alu_val = '0; mem_val = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic issue(input logic [10:0] id, input bit s1, input bit s2);
    iss_v = 1; iss_k = 0; iss_id = id; e1 = s1; e2 = s2;
    iss_pc = {21'h0, id} << 2; iss_imm = 32'h1000 + id; iss_sh = id[5:0]; iss_rob = id[4:0];
  endtask

  task automatic lookup(input bit c1, input logic [4:0] t1, input logic [31:0] v1, input bit h1, input logic [31:0] o1,
                        input bit c2, input logic [4:0] t2, input logic [31:0] v2, input bit h2, input logic [31:0] o2);
    rf1_clean = c1; rf1_tag = t1; rf1_val = v1; rob1_hit = h1; rob1_val = o1;
    rf2_clean = c2; rf2_tag = t2; rf2_val = v2; rob2_hit = h2; rob2_val = o2;
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_eq("R10", "count after reset", free_cnt, 6'd32);
    check_eq("R10", "id after reset", dsp_id, 11'd0);

    // R8 latency with clean register values (R3)
    issue(11'h013, 1, 1); tick();
    check_eq("R8", "no dispatch one edge after issue", dsp_id, 11'd0);
    idle(); lookup(1, 5'd0, 32'hAAAA_0001, 0, '0, 1, 5'd0, 32'hBBBB_0002, 0, '0); tick();
    check_eq("R8", "no dispatch two edges after issue", dsp_id, 11'd0);
    idle(); tick();
    check_eq("R8", "dispatch three edges after issue", dsp_id, 11'h013);
    check_eq("R3", "clean register operand", dsp_op1, 32'hAAAA_0001);

    // R2 issue kind 1 ignored
    issue(11'h055, 1, 1); iss_k = 1; tick();
    check_eq("R2", "count unchanged by kind 1", free_cnt, 6'd32);
    idle(); tick(); tick();
    check_eq("R2", "nothing dispatched after kind 1", dsp_id, 11'd0);

    // R3 reorder-buffer hit
    issue(11'h021, 1, 1); tick();
    idle(); lookup(0, 5'd4, 32'hDEAD, 1, 32'hC0DE_0003, 1, 5'd0, 32'h44, 0, '0); tick(); tick();
    check_eq("R3", "reorder-buffer operand", dsp_op1, 32'hC0DE_0003);

    // R4 bypass in the lookup cycle, one source from each bus
    issue(11'h022, 1, 1); tick();
    idle(); lookup(0, 5'd7, '0, 0, '0, 0, 5'd9, '0, 0, '0);
    alu_stat = 2'b10; alu_tag = 5'd7; alu_val = 32'hD0D0_0004;
    mem_stat = 2'b10; mem_tag = 5'd9; mem_val = 32'hE0E0_0005; tick();
    idle(); tick();
    check_eq("R4", "lookup bypass from ALU", dsp_op1, 32'hD0D0_0004);
    check_eq("R4", "lookup bypass from memory", dsp_op2, 32'hE0E0_0005);

    // R5 wait, invalid status ignored, then capture
    issue(11'h023, 1, 0); tick();
    idle(); lookup(0, 5'd3, '0, 0, '0, 1, '0, '0, 0, '0); tick();
    idle(); alu_stat = 2'b11; alu_tag = 5'd3; alu_val = 32'h1111; tick();
    idle(); tick();
    check_eq("R5", "status 2'b11 not captured", dsp_id, 11'd0);
    mem_stat = 2'b10; mem_tag = 5'd3; mem_val = 32'hF00D_0006; tick();
    idle(); tick();
    check_eq("R5", "late capture dispatched", dsp_id, 11'h023);
    check_eq("R5", "late capture value", dsp_op1, 32'hF00D_0006);

    // R6 absent sources do not wait and read as zero
    issue(11'h024, 0, 0); tick();
    idle(); lookup(0, 5'd1, 32'h5, 0, '0, 0, 5'd2, 32'h6, 0, '0); tick(); tick();
    check_eq("R6", "absent sources dispatched", dsp_id, 11'h024);
    check_eq("R6", "absent operand 2 value", dsp_op2, 32'h0);

    // R1 fill every slot, then R7 lowest-first release
    for (int i = 0; i < N; i++) begin
      issue(11'h100 + 11'(i), 1, 0);
      if (i > 0) lookup(0, 5'd20, '0, 0, '0, 1, '0, '0, 0, '0);
      tick();
    end
    idle(); lookup(0, 5'd20, '0, 0, '0, 1, '0, '0, 0, '0); tick();
    check_eq("R1", "count when full", free_cnt, 6'd0);
    idle(); alu_stat = 2'b10; alu_tag = 5'd20; alu_val = 32'h2020; tick();
    idle(); tick();
    check_eq("R7", "lowest slot dispatched first", dsp_id, 11'h100);
    tick();
    check_eq("R7", "next slot dispatched second", dsp_id, 11'h101);
    repeat (N) tick();

    // R10 flush with entries in flight
    issue(11'h031, 1, 1); tick();
    issue(11'h032, 1, 1); lookup(0, 5'd11, '0, 0, '0, 1, '0, '0, 0, '0); tick();
    idle(); flush = 1; tick();
    check_eq("R10", "count after flush", free_cnt, 6'd32);
    check_eq("R10", "id after flush", dsp_id, 11'd0);
    idle(); repeat (3) tick();

    // random mix
    for (int c = 0; c < 4000; c++) begin
      idle();
      if (m_cnt > 0 && ($urandom % 2) == 1) begin
        issue(11'($urandom % 2047 + 1), 1'($urandom % 2), 1'($urandom % 2));
        iss_k = (($urandom % 5) == 0);
        iss_pc = $urandom; iss_imm = $urandom; iss_rob = 5'($urandom);
      end
      lookup(($urandom % 3) == 0, 5'($urandom % 8), $urandom, ($urandom % 3) == 0, $urandom,
             ($urandom % 3) == 0, 5'($urandom % 8), $urandom, ($urandom % 3) == 0, $urandom);
      alu_stat = 2'($urandom); alu_tag = 5'($urandom % 8); alu_val = $urandom;
      mem_stat = 2'($urandom); mem_tag = 5'($urandom % 8); mem_val = $urandom;
      flush = (($urandom % 250) == 0);
      tick();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule